// File: doc/BRIEF.md
# Privilege and Exception Sequencer

This block is the control heart of a small memory-to-memory processor. It owns the program counter, a one-deep saved program counter and a single privilege bit. Each step presents one instruction to it: its fetch address (the current PC), its decoded flags and the operand addresses it touches. The block checks the step for protection faults against a low reserved address region and decides where execution goes next.

There are four kinds of redirect: a timer interrupt, a protection fault on fetch or operand access, a trap instruction, and an attempt to change the privilege bit from unprivileged code. Each one sends the PC to a fixed entry address of its own. The interrupted PC is kept, and the machine drops into privileged mode. A return instruction swaps the two PCs and re-enters unprivileged mode in a single step.

All outputs are registered, and they change on the clock edge that closes a step. The arithmetic datapath and the memory sit outside the block. They receive the PC and the retire indication, and they use them to commit or discard the work of the instruction.

Top module: `excp_sequencer`

## Requirements
- R1: A synchronous reset sets the PC, the saved PC and the privilege bit to 0, where 0 means privileged (system) and 1 means unprivileged (user). The reset also clears the retire and acknowledge pulses.
- R2: A step with no redirect and no return moves the PC up by 4 and raises `retire_o` for one cycle. A cycle with `step_i` low changes no state, and `retire_o` stays low.
- R3: In user mode, a step whose PC is below 100 is a fetch fault. The PC goes to 60 and the instruction does not retire.
- R4: In user mode, a step with any valid operand slot addressing below 100 is an operand fault that goes to 60. This holds for direct slots and for slots carrying a resolved indirect address alike. An address of exactly 100 is legal. In system mode no operand is checked.
- R5: A user-mode write of the privilege bit goes to 64 and the new value is discarded. In system mode the write takes effect, `wr_mode_val_i` is loaded, and the step retires.
- R6: A trap instruction goes to 68 in either mode.
- R7: An interrupt line that is high on a step goes to 72. One cycle later `irq_ack_o` is high for exactly that cycle. The line is ignored on cycles with `step_i` low.
- R8: Every redirect copies the PC of the stepped instruction into the saved PC and forces the privilege bit to 0.
- R9: A return instruction that is not pre-empted loads the PC from the saved PC, loads the saved PC with the old PC and sets user mode, all on one edge. The step retires.
- R10: When several events fall on one step, only one is taken, in this order: interrupt, fetch fault, trap, privilege-write fault, operand fault, then return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | An instruction at `pc_o` is presented this cycle |
| irq_i | input | 1 | Timer interrupt line |
| is_trap_i | input | 1 | Decoded: trap instruction |
| is_rte_i | input | 1 | Decoded: return from exception |
| wr_mode_i | input | 1 | Decoded: instruction writes the privilege bit |
| wr_mode_val_i | input | 1 | Value to be written to the privilege bit |
| opnd_vld_i | input | NOPND | One valid flag per operand address slot |
| opnd_addr_i | input | NOPND*AW | Packed operand addresses, slot k in bits k*AW upward |
| pc_o | output | AW | Program counter |
| mode_o | output | 1 | Privilege bit (0 system, 1 user) |
| epc_o | output | AW | Saved program counter |
| retire_o | output | 1 | One-cycle pulse: the previous step executed |
| irq_ack_o | output | 1 | One-cycle pulse that resets the timer |

## Verification
The bench goes after the address boundary at 99 and 100, for fetch and for operand slots. A design with an off-by-one compare would either fault on legal code at 100 or let a reserved cell through. It also stacks events on a single step: interrupt with trap, fetch fault with trap and a bad operand, trap with a privilege write, a privilege write with a bad operand. A wrong priority shows up there as the wrong entry address. Each return is checked for a full swap on one edge. A design that updated the PC and the privilege bit in separate cycles, or that lost the old PC, would show a stale `epc_o` or a mode mismatch. Long runs of random steps with held-off cycles and mid-run resets catch any state that moves without a step.

// File: rtl/excp_pkg.sv
package excp_pkg;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_IRQ   = 3'd1,
    EV_FETCH = 3'd2,
    EV_TRAP  = 3'd3,
    EV_MODE  = 3'd4,
    EV_OPND  = 3'd5
  } ev_e;

  localparam logic MODE_SYS = 1'b0;
  localparam logic MODE_USR = 1'b1;

endpackage

// File: rtl/excp_addr_guard.sv
module excp_addr_guard #(
  parameter int AW          = 16,
  parameter int NOPND       = 4,
  parameter int RESV_LIMIT  = 100
) (
  input  logic                  mode_i,
  input  logic [AW-1:0]         pc_i,
  input  logic [NOPND-1:0]      opnd_vld_i,
  input  logic [NOPND*AW-1:0]   opnd_addr_i,
  output logic                  fetch_bad_o,
  output logic                  opnd_bad_o
);
  import excp_pkg::*;

  localparam logic [AW-1:0] LIM = AW'(RESV_LIMIT);

  logic [NOPND-1:0] slot_low;

  for (genvar k = 0; k < NOPND; k++) begin : g_slot
    assign slot_low[k] = opnd_vld_i[k] && (opnd_addr_i[k*AW +: AW] < LIM);
  end

  always_comb begin
    fetch_bad_o = (mode_i == MODE_USR) && (pc_i < LIM);
    opnd_bad_o  = (mode_i == MODE_USR) && (|slot_low);
  end

endmodule

// File: rtl/excp_event_arb.sv
module excp_event_arb (
  input  logic            irq_i,
  input  logic            fetch_bad_i,
  input  logic            is_trap_i,
  input  logic            mode_bad_i,
  input  logic            opnd_bad_i,
  output excp_pkg::ev_e   ev_o
);
  import excp_pkg::*;

  always_comb begin
    if (irq_i)            ev_o = EV_IRQ;
    else if (fetch_bad_i) ev_o = EV_FETCH;
    else if (is_trap_i)   ev_o = EV_TRAP;
    else if (mode_bad_i)  ev_o = EV_MODE;
    else if (opnd_bad_i)  ev_o = EV_OPND;
    else                  ev_o = EV_NONE;
  end

endmodule

// File: rtl/excp_ctx_regs.sv
module excp_ctx_regs #(
  parameter int AW          = 16,
  parameter int INSTR_BYTES = 4,
  parameter int VEC_MEM     = 60,
  parameter int VEC_MODE    = 64,
  parameter int VEC_TRAP    = 68,
  parameter int VEC_IRQ     = 72
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  excp_pkg::ev_e   ev_i,
  input  logic            is_rte_i,
  input  logic            wr_mode_i,
  input  logic            wr_mode_val_i,
  output logic [AW-1:0]   pc_o,
  output logic [AW-1:0]   epc_o,
  output logic            mode_o,
  output logic            retire_o,
  output logic            irq_ack_o
);
  import excp_pkg::*;

  localparam logic [AW-1:0] PC_INC = AW'(INSTR_BYTES);

  logic [AW-1:0] entry;

  always_comb begin
    unique case (ev_i)
      EV_IRQ:           entry = AW'(VEC_IRQ);
      EV_TRAP:          entry = AW'(VEC_TRAP);
      EV_MODE:          entry = AW'(VEC_MODE);
      EV_FETCH, EV_OPND: entry = AW'(VEC_MEM);
      default:          entry = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o      <= '0;
      epc_o     <= '0;
      mode_o    <= MODE_SYS;
      retire_o  <= 1'b0;
      irq_ack_o <= 1'b0;
    end else begin
      retire_o  <= 1'b0;
      irq_ack_o <= 1'b0;
      if (step_i) begin
        if (ev_i == EV_NONE) begin
          retire_o <= 1'b1;
          if (is_rte_i) begin
            pc_o   <= epc_o;
            epc_o  <= pc_o;
            mode_o <= MODE_USR;
          end else begin
            if (wr_mode_i) mode_o <= wr_mode_val_i;
            pc_o <= pc_o + PC_INC;
          end
        end else begin
          epc_o     <= pc_o;
          pc_o      <= entry;
          mode_o    <= MODE_SYS;
          irq_ack_o <= (ev_i == EV_IRQ);
        end
      end
    end
  end

endmodule

// File: rtl/excp_sequencer.sv
module excp_sequencer #(
  parameter int AW          = 16,
  parameter int NOPND       = 4,
  parameter int RESV_LIMIT  = 100,
  parameter int INSTR_BYTES = 4,
  parameter int VEC_MEM     = 60,
  parameter int VEC_MODE    = 64,
  parameter int VEC_TRAP    = 68,
  parameter int VEC_IRQ     = 72
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_i,
  input  logic                 irq_i,
  input  logic                 is_trap_i,
  input  logic                 is_rte_i,
  input  logic                 wr_mode_i,
  input  logic                 wr_mode_val_i,
  input  logic [NOPND-1:0]     opnd_vld_i,
  input  logic [NOPND*AW-1:0]  opnd_addr_i,
  output logic [AW-1:0]        pc_o,
  output logic                 mode_o,
  output logic [AW-1:0]        epc_o,
  output logic                 retire_o,
  output logic                 irq_ack_o
);
  import excp_pkg::*;

  logic fetch_bad, opnd_bad, mode_bad;
  ev_e  ev;

  excp_addr_guard #(
    .AW(AW), .NOPND(NOPND), .RESV_LIMIT(RESV_LIMIT)
  ) u_guard (
    .mode_i      (mode_o),
    .pc_i        (pc_o),
    .opnd_vld_i  (opnd_vld_i),
    .opnd_addr_i (opnd_addr_i),
    .fetch_bad_o (fetch_bad),
    .opnd_bad_o  (opnd_bad)
  );

  assign mode_bad = wr_mode_i && (mode_o == MODE_USR);

  excp_event_arb u_arb (
    .irq_i       (irq_i),
    .fetch_bad_i (fetch_bad),
    .is_trap_i   (is_trap_i),
    .mode_bad_i  (mode_bad),
    .opnd_bad_i  (opnd_bad),
    .ev_o        (ev)
  );

  excp_ctx_regs #(
    .AW(AW), .INSTR_BYTES(INSTR_BYTES), .VEC_MEM(VEC_MEM),
    .VEC_MODE(VEC_MODE), .VEC_TRAP(VEC_TRAP), .VEC_IRQ(VEC_IRQ)
  ) u_ctx (
    .clk           (clk),
    .rst           (rst),
    .step_i        (step_i),
    .ev_i          (ev),
    .is_rte_i      (is_rte_i),
    .wr_mode_i     (wr_mode_i),
    .wr_mode_val_i (wr_mode_val_i),
    .pc_o          (pc_o),
    .epc_o         (epc_o),
    .mode_o        (mode_o),
    .retire_o      (retire_o),
    .irq_ack_o     (irq_ack_o)
  );

endmodule

// File: rtl/excp_sequencer_chk.sv
module excp_sequencer_chk #(
  parameter int AW         = 16,
  parameter int RESV_LIMIT = 100,
  parameter int VEC_MEM    = 60,
  parameter int VEC_MODE   = 64,
  parameter int VEC_TRAP   = 68,
  parameter int VEC_IRQ    = 72
) (
  input logic          clk,
  input logic          rst,
  input logic          step_i,
  input logic          irq_i,
  input logic          is_trap_i,
  input logic          is_rte_i,
  input logic          wr_mode_i,
  input logic [AW-1:0] pc_o,
  input logic          mode_o,
  input logic [AW-1:0] epc_o,
  input logic          retire_o,
  input logic          irq_ack_o
);
  localparam logic [AW-1:0] LIM = AW'(RESV_LIMIT);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(pc_o) && $stable(mode_o) && $stable(epc_o) && !retire_o);

  assert_fetch_fault_R3: assert property (@(posedge clk) disable iff (rst)
    step_i && !irq_i && mode_o && (pc_o < LIM) |=>
      pc_o == AW'(VEC_MEM) && !mode_o && !retire_o && epc_o == $past(pc_o));

  assert_mode_fault_R5: assert property (@(posedge clk) disable iff (rst)
    step_i && !irq_i && mode_o && (pc_o >= LIM) && !is_trap_i && wr_mode_i |=>
      pc_o == AW'(VEC_MODE) && !mode_o && !retire_o);

  assert_trap_R6: assert property (@(posedge clk) disable iff (rst)
    step_i && !irq_i && !(mode_o && (pc_o < LIM)) && is_trap_i |=>
      pc_o == AW'(VEC_TRAP) && !mode_o && epc_o == $past(pc_o));

  assert_irq_take_R7: assert property (@(posedge clk) disable iff (rst)
    step_i && irq_i |=> irq_ack_o && pc_o == AW'(VEC_IRQ) && !mode_o
      && epc_o == $past(pc_o));

  assert_ack_cause_R7: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |-> $past(step_i && irq_i));

  assert_mode_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_o) |-> $past(step_i && (is_rte_i || wr_mode_i)));

  assert_rte_swap_R9: assert property (@(posedge clk) disable iff (rst)
    step_i && !irq_i && !mode_o && !is_trap_i && is_rte_i |=>
      pc_o == $past(epc_o) && epc_o == $past(pc_o) && mode_o && retire_o);

  assert_retire_legal_R4: assert property (@(posedge clk) disable iff (rst)
    retire_o && $past(mode_o) |-> $past(pc_o) >= LIM);

endmodule

bind excp_sequencer excp_sequencer_chk #(
  .AW(AW), .RESV_LIMIT(RESV_LIMIT), .VEC_MEM(VEC_MEM),
  .VEC_MODE(VEC_MODE), .VEC_TRAP(VEC_TRAP), .VEC_IRQ(VEC_IRQ)
) chk_i (
  .clk(clk), .rst(rst), .step_i(step_i), .irq_i(irq_i),
  .is_trap_i(is_trap_i), .is_rte_i(is_rte_i), .wr_mode_i(wr_mode_i),
  .pc_o(pc_o), .mode_o(mode_o), .epc_o(epc_o),
  .retire_o(retire_o), .irq_ack_o(irq_ack_o)
);

// File: tb/excp_sequencer_tb_top.sv
module excp_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NOPND = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 0, irq_i = 0, is_trap_i = 0, is_rte_i = 0;
  logic wr_mode_i = 0, wr_mode_val_i = 0;
  logic [NOPND-1:0] opnd_vld_i = '0;
  logic [NOPND*AW-1:0] opnd_addr_i = '0;
  logic [AW-1:0] pc_o, epc_o;
  logic mode_o, retire_o, irq_ack_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  excp_sequencer dut_i (
    .clk(clk), .rst(rst), .step_i(step_i), .irq_i(irq_i),
    .is_trap_i(is_trap_i), .is_rte_i(is_rte_i), .wr_mode_i(wr_mode_i),
    .wr_mode_val_i(wr_mode_val_i), .opnd_vld_i(opnd_vld_i),
    .opnd_addr_i(opnd_addr_i), .pc_o(pc_o), .mode_o(mode_o),
    .epc_o(epc_o), .retire_o(retire_o), .irq_ack_o(irq_ack_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference state
  int m_pc = 0, m_epc = 0;
  bit m_mode = 0, m_ack = 0, m_ret = 0;
  string m_tag = "R1";

  function automatic void take(int vec);
    m_epc  = m_pc;
    m_pc   = vec;
    m_mode = 0;
  endfunction

  function automatic void model_step();
    bit obad;
    m_ack = 0; m_ret = 0;
    if (rst) begin
      m_pc = 0; m_epc = 0; m_mode = 0; m_tag = "R1";
    end else if (!step_i) begin
      m_tag = "R2 hold";
    end else begin
      obad = 0;
      for (int k = 0; k < NOPND; k++)
        if (opnd_vld_i[k] && int'(opnd_addr_i[k*AW +: AW]) < 100) obad = 1;
      if (irq_i)                          begin take(72); m_ack = 1; m_tag = "R7"; end
      else if (m_mode && m_pc < 100)      begin take(60); m_tag = "R3"; end
      else if (is_trap_i)                 begin take(68); m_tag = "R6"; end
      else if (wr_mode_i && m_mode)       begin take(64); m_tag = "R5"; end
      else if (m_mode && obad)            begin take(60); m_tag = "R4"; end
      else if (is_rte_i) begin
        int t = m_pc; m_pc = m_epc; m_epc = t; m_mode = 1; m_ret = 1; m_tag = "R9";
      end else begin
        if (wr_mode_i) m_mode = wr_mode_val_i;
        m_pc = (m_pc + 4) & 16'hFFFF; m_ret = 1; m_tag = "R2";
      end
    end
  endfunction

  // called at a negedge with inputs set; compares after the next posedge
  task automatic tick(input string note);
    model_step();
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (pc_o !== AW'(m_pc) || epc_o !== AW'(m_epc) || mode_o !== m_mode ||
        retire_o !== m_ret || irq_ack_o !== m_ack) begin
      n_fail++;
      $display("FAIL %s %s: pc=%0d epc=%0d mode=%0b ret=%0b ack=%0b expected pc=%0d epc=%0d mode=%0b ret=%0b ack=%0b",
               m_tag, note, pc_o, epc_o, mode_o, retire_o, irq_ack_o,
               m_pc, m_epc, m_mode, m_ret, m_ack);
    end
  endtask

  task automatic clr();
    step_i = 1; irq_i = 0; is_trap_i = 0; is_rte_i = 0;
    wr_mode_i = 0; wr_mode_val_i = 0; opnd_vld_i = '0; opnd_addr_i = '0;
  endtask

  task automatic set_op(input int slot, input int addr);
    opnd_vld_i[slot] = 1'b1;
    opnd_addr_i[slot*AW +: AW] = AW'(addr);
  endtask

  task automatic do_reset();
    rst = 1; clr(); step_i = 0;
    tick("R1 reset");
    rst = 0;
  endtask

  // system mode: run up to 200, trap there, return into user mode at 200
  task automatic go_user200();
    clr();
    while (m_pc != 200) tick("R2 advance");
    clr(); is_trap_i = 1; tick("R6 trap sys");
    clr(); is_rte_i = 1;  tick("R9 return");
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    do_reset();
    // R4: system mode ignores low operands
    clr(); set_op(0, 10); set_op(1, 0); tick("R4 sys no check");
    clr(); step_i = 0; irq_i = 1; tick("R7 irq ignored w/o step");
    go_user200();
    clr(); set_op(3, 100); tick("R4 boundary 100 legal");
    clr(); set_op(2, 99); tick("R4 operand 99 faults");
    clr(); is_rte_i = 1; tick("R9 back");
    clr(); wr_mode_i = 1; wr_mode_val_i = 0; tick("R5 user mode write");
    clr(); is_rte_i = 1; tick("R9 back");
    clr(); is_trap_i = 1; tick("R6 user trap R8");
    clr(); is_rte_i = 1; tick("R9 back");
    clr(); irq_i = 1; is_trap_i = 1; wr_mode_i = 1; tick("R10 irq first");
    clr(); step_i = 0; tick("R7 ack one cycle");
    clr(); wr_mode_i = 1; wr_mode_val_i = 1; tick("R5 sys mode write");
    clr(); is_trap_i = 1; set_op(0, 5); tick("R10 fetch before trap");
    do_reset();
    go_user200();
    clr(); is_trap_i = 1; wr_mode_i = 1; tick("R10 trap before mode");
    clr(); is_rte_i = 1; tick("R9 back");
    clr(); wr_mode_i = 1; set_op(1, 3); tick("R10 mode before operand");
    clr(); is_rte_i = 1; tick("R9 back");
    clr(); is_rte_i = 1; set_op(0, 50); tick("R10 operand before return");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      clr();
      rst           = ($urandom_range(0, 199) == 0);
      step_i        = ($urandom_range(0, 9) < 8);
      irq_i         = ($urandom_range(0, 19) == 0);
      is_trap_i     = ($urandom_range(0, 11) == 0);
      is_rte_i      = ($urandom_range(0, 7) == 0);
      wr_mode_i     = ($urandom_range(0, 11) == 0);
      wr_mode_val_i = 1'($urandom_range(0, 1));
      for (int k = 0; k < NOPND; k++)
        if ($urandom_range(0, 3) == 0) set_op(k, $urandom_range(90, 400));
      tick("random R10");
    end
    rst = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule